// File: doc/BRIEF.md
# Windowed Local-Maximum Location Memory

This block is a 32-bit on-chip memory for image tiles. It serves two purposes. First, it acts as a plain dual-port RAM. Second, it can find where the largest pixel of a 3x3 neighbourhood lies, in a single access. The stored tile is 12 image rows of 32 pixels. Image row `r` goes to bank `r mod 3`, at internal word `(r div 3)*32 + column`. Because of this placement, three vertically adjacent image rows always sit in three different banks. Each bank reads three neighbouring words of its row in the same cycle, and picks the largest of them together with its offset. A final stage compares the three row winners and forms the address of the overall winner.

In normal operation, ports A and B are independent. Each port can write one word, or read one word back one cycle later. A search takes over port A's address and blocks all normal traffic for that cycle. The search address names the top-left pixel of the window. The location of the maximum appears, with a valid flag, two clock edges after the request. A new search may be issued in every cycle. Windows that would extend past the right or bottom edge of the tile are outside the contract.

Top module: `lmx_winmax_mem`

## Requirements
- R1: A port A write stores a 32-bit word at address {bank[8:7], word[6:0]}. A port A read returns the stored word on `a_rdata` after the next rising edge.
- R2: Port B behaves like port A and is fully independent of it. Both ports may access different addresses in the same cycle.
- R3: When both ports write the same address in the same cycle, the port B data is kept.
- R4: Bank field value 3 selects no storage. Writes to it change nothing, reads from it return zero, and a search request naming it produces no result.
- R5: A search request at an edge raises `res_valid` for exactly one cycle, two edges later. `res_valid` is otherwise low, and back-to-back requests give back-to-back results.
- R6: For a search at {b0, a}, the window rows are banks b0, b0+1, b0+2 (mod 3), in that order. Each bank starts at word a, except banks numbered below b0, which start at a+32. `res_addr` is {winning bank, that bank's start + offset 0..2}, and it locates the largest of the nine pixels.
- R7: A window whose three columns cross a group of four words (start column mod 4 equal to 2 or 3) gives the correct result.
- R8: Among equal maxima in one window row, the lowest offset wins.
- R9: Among equal row maxima, the earliest window row (b0 first) wins.
- R10: During a search cycle, port A's write and all port B activity are ignored.
- R11: While reset is high and after it, `res_valid` and `res_addr` read zero until a search completes.
- R12: Pixels are compared as unsigned numbers, so 0x80000000 beats 0x7FFFFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| a_en | input | 1 | Port A access enable |
| a_we | input | 1 | Port A write enable |
| a_addr | input | 9 | Port A address, also the search window origin |
| a_wdata | input | 32 | Port A write data |
| a_rdata | output | 32 | Port A read data |
| b_en | input | 1 | Port B access enable |
| b_we | input | 1 | Port B write enable |
| b_addr | input | 9 | Port B address |
| b_wdata | input | 32 | Port B write data |
| b_rdata | output | 32 | Port B read data |
| srch_req | input | 1 | Start a window search at a_addr |
| res_valid | output | 1 | Search result valid |
| res_addr | output | 9 | Address of the window maximum |

## Verification
The search is exercised in several ways:
- A sweep of windows over every starting bank and many columns, on pseudo-random pixel contents. This separates the bank rotation and the +32 row step of banks below the first one.
- Windows starting in columns 2 and 3 of a four-word group, with the maximum placed in the last column. These catch a wrong next-row selection.
- Windows with planted equal values, inside one row and across rows. These pin down both tie rules.
- A sign-bit pair, which distinguishes unsigned from signed comparison.
- Searches issued while port writes are driven. These show that those writes are blocked.

// File: rtl/lmx_pkg.sv
package lmx_pkg;

  localparam int DEF_DATA_W    = 32;
  localparam int DEF_ROW_WORDS = 4;
  localparam int DEF_PHYS_ROWS = 32;
  localparam int DEF_IMG_W     = 32;

  localparam int NUM_BANKS = 3;
  localparam int WIN       = 3;
  localparam int BANK_W    = 2;
  localparam int OFF_W     = 2;

  typedef logic [BANK_W-1:0] bank_id_t;
  typedef logic [OFF_W-1:0]  win_off_t;

  // bank that holds window row `row` when the window starts in bank `first`
  function automatic bank_id_t row_bank(input bank_id_t first, input int unsigned row);
    int unsigned s;
    s = int'(first) + row;
    if (s >= NUM_BANKS) s = s - NUM_BANKS;
    return bank_id_t'(s);
  endfunction

endpackage

// File: rtl/lmx_colmem.sv
module lmx_colmem #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 32,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              a_en,
  input  logic              a_we,
  input  logic [AW-1:0]     a_addr,
  input  logic [DATA_W-1:0] a_wdata,
  output logic [DATA_W-1:0] a_rdata,
  input  logic              b_en,
  input  logic              b_we,
  input  logic [AW-1:0]     b_addr,
  input  logic [DATA_W-1:0] b_wdata,
  output logic [DATA_W-1:0] b_rdata
);

  logic [DATA_W-1:0] mem [DEPTH];

  // true dual-port, read-first; on a shared write address port B lands last
  always_ff @(posedge clk) begin
    if (a_en) begin
      if (a_we) mem[a_addr] <= a_wdata;
      a_rdata <= mem[a_addr];
    end
    if (b_en) begin
      if (b_we) mem[b_addr] <= b_wdata;
      b_rdata <= mem[b_addr];
    end
  end

endmodule

// File: rtl/lmx_bank.sv
module lmx_bank
  import lmx_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int ROW_WORDS = 4,
  parameter int PHYS_ROWS = 32,
  localparam int COL_W    = $clog2(ROW_WORDS),
  localparam int ROW_W    = $clog2(PHYS_ROWS),
  localparam int IAW      = COL_W + ROW_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              srch,
  input  logic [IAW-1:0]    s_addr,
  input  logic              a_en,
  input  logic              a_we,
  input  logic [IAW-1:0]    a_addr,
  input  logic [DATA_W-1:0] a_wdata,
  input  logic              b_en,
  input  logic              b_we,
  input  logic [IAW-1:0]    b_addr,
  input  logic [DATA_W-1:0] b_wdata,
  output logic [DATA_W-1:0] a_rdata,
  output logic [DATA_W-1:0] b_rdata,
  output logic [DATA_W-1:0] max_val,
  output win_off_t          max_off,
  output logic [IAW-1:0]    start_q
);

  logic [COL_W-1:0] s_col, a_col, b_col;
  logic [ROW_W-1:0] s_row, s_row_nx, a_row, b_row;

  assign {s_row, s_col} = s_addr;
  assign {a_row, a_col} = a_addr;
  assign {b_row, b_col} = b_addr;
  assign s_row_nx       = s_row + 1'b1;

  logic [DATA_W-1:0] col_qa [ROW_WORDS];
  logic [DATA_W-1:0] col_qb [ROW_WORDS];

  // one memory per word column; a search reads the start row in columns at or
  // right of the start column and the following row in columns to its left
  for (genvar k = 0; k < ROW_WORDS; k++) begin : g_col
    logic             pa_en, pa_we, pb_en, pb_we;
    logic [ROW_W-1:0] pa_addr;

    always_comb begin
      pa_en   = srch | (a_en & (a_col == COL_W'(k)));
      pa_we   = ~srch & a_en & a_we & (a_col == COL_W'(k));
      pa_addr = srch ? ((COL_W'(k) >= s_col) ? s_row : s_row_nx) : a_row;
      pb_en   = ~srch & b_en & (b_col == COL_W'(k));
      pb_we   = pb_en & b_we;
    end

    lmx_colmem #(.DATA_W(DATA_W), .DEPTH(PHYS_ROWS)) u_colmem (
      .clk     (clk),
      .a_en    (pa_en),
      .a_we    (pa_we),
      .a_addr  (pa_addr),
      .a_wdata (a_wdata),
      .a_rdata (col_qa[k]),
      .b_en    (pb_en),
      .b_we    (pb_we),
      .b_addr  (b_row),
      .b_wdata (b_wdata),
      .b_rdata (col_qb[k])
    );
  end

  logic [COL_W-1:0] a_col_q, b_col_q, s_col_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      a_col_q <= '0;
      b_col_q <= '0;
      s_col_q <= '0;
      start_q <= '0;
    end else begin
      if (!srch && a_en) a_col_q <= a_col;
      if (!srch && b_en) b_col_q <= b_col;
      if (srch) begin
        s_col_q <= s_col;
        start_q <= s_addr;
      end
    end
  end

  assign a_rdata = col_qa[a_col_q];
  assign b_rdata = col_qb[b_col_q];

  logic [DATA_W-1:0] win_w [WIN];

  for (genvar j = 0; j < WIN; j++) begin : g_win
    logic [COL_W-1:0] wc;
    assign wc       = s_col_q + COL_W'(j);
    assign win_w[j] = col_qa[wc];
  end

  // strict greater-than keeps the lowest offset on ties
  always_comb begin
    max_val = win_w[0];
    max_off = '0;
    for (int j = 1; j < WIN; j++) begin
      if (win_w[j] > max_val) begin
        max_val = win_w[j];
        max_off = win_off_t'(j);
      end
    end
  end

endmodule

// File: rtl/lmx_final_sel.sv
module lmx_final_sel
  import lmx_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IAW    = 7
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              go,
  input  bank_id_t                          first,
  input  logic [NUM_BANKS-1:0][DATA_W-1:0]  bank_val,
  input  win_off_t [NUM_BANKS-1:0]          bank_off,
  input  logic [NUM_BANKS-1:0][IAW-1:0]     bank_start,
  output logic                              res_valid,
  output logic [BANK_W+IAW-1:0]             res_addr
);

  bank_id_t          best_bank;
  logic [DATA_W-1:0] best_val;
  logic [IAW-1:0]    best_low;

  // rows scanned in window order; strict compare keeps the earliest row on ties
  always_comb begin
    best_bank = row_bank(first, 0);
    best_val  = bank_val[best_bank];
    for (int i = 1; i < WIN; i++) begin
      if (bank_val[row_bank(first, i)] > best_val) begin
        best_bank = row_bank(first, i);
        best_val  = bank_val[best_bank];
      end
    end
    best_low = bank_start[best_bank] + IAW'(bank_off[best_bank]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      res_addr  <= '0;
    end else begin
      res_valid <= go;
      if (go) res_addr <= {best_bank, best_low};
    end
  end

endmodule

// File: rtl/lmx_winmax_mem.sv
module lmx_winmax_mem
  import lmx_pkg::*;
#(
  parameter int DATA_W    = DEF_DATA_W,
  parameter int ROW_WORDS = DEF_ROW_WORDS,
  parameter int PHYS_ROWS = DEF_PHYS_ROWS,
  parameter int IMG_W     = DEF_IMG_W,
  localparam int COL_W    = $clog2(ROW_WORDS),
  localparam int ROW_W    = $clog2(PHYS_ROWS),
  localparam int IAW      = COL_W + ROW_W,
  localparam int AW       = BANK_W + IAW,
  localparam int ROW_SPAN = IMG_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              a_en,
  input  logic              a_we,
  input  logic [AW-1:0]     a_addr,
  input  logic [DATA_W-1:0] a_wdata,
  output logic [DATA_W-1:0] a_rdata,
  input  logic              b_en,
  input  logic              b_we,
  input  logic [AW-1:0]     b_addr,
  input  logic [DATA_W-1:0] b_wdata,
  output logic [DATA_W-1:0] b_rdata,
  input  logic              srch_req,
  output logic              res_valid,
  output logic [AW-1:0]     res_addr
);

  bank_id_t       a_bank, b_bank;
  logic [IAW-1:0] a_int, b_int;
  logic           nrm, srch_go;

  assign {a_bank, a_int} = a_addr;
  assign {b_bank, b_int} = b_addr;
  assign nrm     = ~srch_req;
  assign srch_go = srch_req && (a_bank < bank_id_t'(NUM_BANKS));

  logic [NUM_BANKS-1:0][DATA_W-1:0] bank_a_rd, bank_b_rd, bank_val;
  win_off_t [NUM_BANKS-1:0]         bank_off;
  logic [NUM_BANKS-1:0][IAW-1:0]    bank_start;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic [IAW-1:0] s_addr_b;
    // banks numbered below the first window row hold the next row group
    assign s_addr_b = (bank_id_t'(b) < a_bank) ? a_int + IAW'(ROW_SPAN) : a_int;

    lmx_bank #(
      .DATA_W   (DATA_W),
      .ROW_WORDS(ROW_WORDS),
      .PHYS_ROWS(PHYS_ROWS)
    ) u_bank (
      .clk     (clk),
      .rst     (rst),
      .srch    (srch_go),
      .s_addr  (s_addr_b),
      .a_en    (nrm & a_en & (a_bank == bank_id_t'(b))),
      .a_we    (a_we),
      .a_addr  (a_int),
      .a_wdata (a_wdata),
      .b_en    (nrm & b_en & (b_bank == bank_id_t'(b))),
      .b_we    (b_we),
      .b_addr  (b_int),
      .b_wdata (b_wdata),
      .a_rdata (bank_a_rd[b]),
      .b_rdata (bank_b_rd[b]),
      .max_val (bank_val[b]),
      .max_off (bank_off[b]),
      .start_q (bank_start[b])
    );
  end

  bank_id_t a_sel_q, b_sel_q, first_q;
  logic     srch_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      a_sel_q <= '0;
      b_sel_q <= '0;
      first_q <= '0;
      srch_q  <= 1'b0;
    end else begin
      srch_q <= srch_go;
      if (srch_go) first_q <= a_bank;
      if (nrm && a_en) a_sel_q <= a_bank;
      if (nrm && b_en) b_sel_q <= b_bank;
    end
  end

  always_comb begin
    case (a_sel_q)
      2'd0:    a_rdata = bank_a_rd[0];
      2'd1:    a_rdata = bank_a_rd[1];
      2'd2:    a_rdata = bank_a_rd[2];
      default: a_rdata = '0;
    endcase
    case (b_sel_q)
      2'd0:    b_rdata = bank_b_rd[0];
      2'd1:    b_rdata = bank_b_rd[1];
      2'd2:    b_rdata = bank_b_rd[2];
      default: b_rdata = '0;
    endcase
  end

  lmx_final_sel #(.DATA_W(DATA_W), .IAW(IAW)) u_final (
    .clk        (clk),
    .rst        (rst),
    .go         (srch_q),
    .first      (first_q),
    .bank_val   (bank_val),
    .bank_off   (bank_off),
    .bank_start (bank_start),
    .res_valid  (res_valid),
    .res_addr   (res_addr)
  );

endmodule

// File: rtl/lmx_winmax_mem_chk.sv
module lmx_winmax_mem_chk #(
  parameter int IAW      = 7,
  parameter int ROW_SPAN = 32,
  localparam int AW      = IAW + 2
) (
  input logic          clk,
  input logic          rst,
  input logic [AW-1:0] a_addr,
  input logic          srch_req,
  input logic          res_valid,
  input logic [AW-1:0] res_addr
);

  logic          legal_req;
  logic [AW-1:0] addr_d1, addr_d2;
  logic [IAW-1:0] delta;

  assign legal_req = srch_req && (a_addr[AW-1 -: 2] != 2'd3);
  assign delta     = res_addr[IAW-1:0] - addr_d2[IAW-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_d1 <= '0;
      addr_d2 <= '0;
    end else begin
      addr_d1 <= a_addr;
      addr_d2 <= addr_d1;
    end
  end

  // R5
  valid_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
    legal_req |=> ##1 res_valid);

  // R5
  no_spurious_valid_chk: assert property (@(posedge clk) disable iff (rst)
    !legal_req |=> ##1 !res_valid);

  // R6
  bank_field_legal_chk: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> res_addr[AW-1 -: 2] != 2'd3);

  // R6
  offset_window_chk: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> ((res_addr[AW-1 -: 2] < addr_d2[AW-1 -: 2])
                   ? (int'(delta) >= ROW_SPAN && int'(delta) <= ROW_SPAN + 2)
                   : (int'(delta) <= 2)));

endmodule

bind lmx_winmax_mem lmx_winmax_mem_chk #(.IAW(IAW), .ROW_SPAN(ROW_SPAN)) u_chk (.*);

// File: tb/lmx_winmax_mem_bench.sv
module lmx_winmax_mem_bench;

  logic        clk = 1'b0;
  logic        rst;
  logic        a_en, a_we, b_en, b_we, srch_req;
  logic [8:0]  a_addr, b_addr;
  logic [31:0] a_wdata, b_wdata;
  logic [31:0] a_rdata, b_rdata;
  logic        res_valid;
  logic [8:0]  res_addr;

  always #5 clk = ~clk;

  lmx_winmax_mem u_lmx_winmax_mem (
    .clk(clk), .rst(rst),
    .a_en(a_en), .a_we(a_we), .a_addr(a_addr), .a_wdata(a_wdata), .a_rdata(a_rdata),
    .b_en(b_en), .b_we(b_we), .b_addr(b_addr), .b_wdata(b_wdata), .b_rdata(b_rdata),
    .srch_req(srch_req), .res_valid(res_valid), .res_addr(res_addr)
  );

  logic [31:0] mdl [0:383];
  int checks = 0;
  int errors = 0;
  int cyc = 0;
  logic [8:0] q_addr [$];
  int         q_cyc  [$];
  string      q_tag  [$];

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [8:0] pix(input int r, input int c);
    return {2'(r % 3), 7'((r / 3) * 32 + c)};
  endfunction

  function automatic int lin(input logic [8:0] ad);
    return int'(ad[8:7]) * 128 + int'(ad[6:0]);
  endfunction

  function automatic logic [31:0] ref_rd(input logic [8:0] ad);
    if (ad[8:7] == 2'd3) return 32'h0;
    return mdl[lin(ad)];
  endfunction

  // R6 R8 R9 R12: reference scan in window-row then offset order, strict compare
  function automatic logic [8:0] ref_srch(input logic [8:0] ad);
    int b0;
    int a;
    logic [31:0] best;
    logic [8:0]  ba;
    b0 = int'(ad[8:7]);
    a = int'(ad[6:0]);
    best = 32'h0;
    ba = 9'h0;
    for (int i = 0; i < 3; i++) begin
      int bk;
      int st;
      bk = (b0 + i) % 3;
      st = (bk < b0) ? a + 32 : a;
      for (int j = 0; j < 3; j++) begin
        logic [31:0] v;
        v = mdl[bk * 128 + st + j];
        if ((i == 0 && j == 0) || v > best) begin
          best = v;
          ba = {2'(bk), 7'(st + j)};
        end
      end
    end
    return ba;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr_a(input logic [8:0] ad, input logic [31:0] d);
    a_en = 1'b1; a_we = 1'b1; a_addr = ad; a_wdata = d;
    @(negedge clk);
    a_en = 1'b0; a_we = 1'b0;
    if (ad[8:7] != 2'd3) mdl[lin(ad)] = d;
  endtask

  task automatic wr2(input logic [8:0] ada, input logic [31:0] da,
                     input logic [8:0] adb, input logic [31:0] db);
    a_en = 1'b1; a_we = 1'b1; a_addr = ada; a_wdata = da;
    b_en = 1'b1; b_we = 1'b1; b_addr = adb; b_wdata = db;
    @(negedge clk);
    a_en = 1'b0; a_we = 1'b0; b_en = 1'b0; b_we = 1'b0;
    if (ada[8:7] != 2'd3) mdl[lin(ada)] = da;
    if (adb[8:7] != 2'd3) mdl[lin(adb)] = db;
  endtask

  task automatic rd_chk(input logic [8:0] ad, input string tag);
    a_en = 1'b1; a_we = 1'b0; a_addr = ad;
    @(negedge clk);
    a_en = 1'b0;
    check(a_rdata === ref_rd(ad), tag, a_rdata, ref_rd(ad));
  endtask

  task automatic rd2_chk(input logic [8:0] ada, input logic [8:0] adb, input string tag);
    a_en = 1'b1; a_we = 1'b0; a_addr = ada;
    b_en = 1'b1; b_we = 1'b0; b_addr = adb;
    @(negedge clk);
    a_en = 1'b0; b_en = 1'b0;
    check(a_rdata === ref_rd(ada), {tag, " port A"}, a_rdata, ref_rd(ada));
    check(b_rdata === ref_rd(adb), {tag, " port B"}, b_rdata, ref_rd(adb));
  endtask

  // driver: pushes the expected item, then issues the request for one cycle
  task automatic srch_exp(input logic [8:0] ad, input logic [8:0] exp, input string tag);
    q_addr.push_back(exp);
    q_cyc.push_back(cyc + 2);
    q_tag.push_back(tag);
    srch_req = 1'b1; a_addr = ad;
    @(negedge clk);
    srch_req = 1'b0;
  endtask

  task automatic fill_win(input int r, input int c, input int base);
    for (int i = 0; i < 3; i++)
      for (int j = 0; j < 3; j++)
        wr_a(pix(r + i, c + j), 32'(base + i * 3 + j));
  endtask

  // monitor: pops and compares as results appear
  always @(negedge clk) begin
    logic [8:0] ea;
    int ec;
    string et;
    if (!rst) begin
      if (res_valid) begin
        if (q_addr.size() == 0) begin
          check(1'b0, "R5 result without request", 32'(res_addr), 32'h0);
        end else begin
          ea = q_addr.pop_front();
          ec = q_cyc.pop_front();
          et = q_tag.pop_front();
          check(cyc == ec, {et, " R5 latency"}, 32'(cyc), 32'(ec));
          check(res_addr === ea, et, 32'(res_addr), 32'(ea));
        end
      end else if (q_cyc.size() > 0 && q_cyc[0] <= cyc) begin
        ea = q_addr.pop_front();
        ec = q_cyc.pop_front();
        et = q_tag.pop_front();
        check(1'b0, {et, " R5 missing result"}, 32'(cyc), 32'(ec));
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=done", cyc);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1;
    a_en = 0; a_we = 0; b_en = 0; b_we = 0; srch_req = 0;
    a_addr = '0; b_addr = '0; a_wdata = '0; b_wdata = '0;
    repeat (3) @(negedge clk);
    // R11
    check(res_valid === 1'b0, "R11 valid in reset", 32'(res_valid), 32'h0);
    check(res_addr === 9'h0, "R11 address in reset", 32'(res_addr), 32'h0);
    rst = 1'b0;
    @(negedge clk);
    check(res_valid === 1'b0, "R11 valid after reset", 32'(res_valid), 32'h0);

    for (int i = 0; i < 192; i++) begin
      logic [31:0] va;
      logic [31:0] vb;
      va = (32'(i) * 32'h9E3779B1) ^ (32'(i) << 11);
      vb = (32'(i + 192) * 32'h9E3779B1) ^ (32'(i + 192) << 11);
      wr2({2'(i / 128), 7'(i % 128)}, va, {2'(((i + 192) / 128)), 7'((i + 192) % 128)}, vb);
    end

    // R1
    rd_chk(9'h000, "R1 read bank0");
    rd_chk(9'h0A3, "R1 read bank1");
    rd_chk(9'h17F, "R1 read bank2");
    wr_a(9'h045, 32'h1234_5678);
    rd_chk(9'h045, "R1 write then read");
    // R2
    wr2(9'h011, 32'hAAAA_0001, 9'h112, 32'hBBBB_0002);
    rd2_chk(9'h011, 9'h112, "R2 dual write");
    rd2_chk(9'h112, 9'h011, "R2 crossed reads");
    // R3
    wr2(9'h0C7, 32'h1111_1111, 9'h0C7, 32'h2222_2222);
    rd_chk(9'h0C7, "R3 collision keeps B");
    check(a_rdata === 32'h2222_2222, "R3 collision literal", a_rdata, 32'h2222_2222);
    // R4
    wr_a({2'd3, 7'd5}, 32'hDEAD_BEEF);
    rd_chk({2'd0, 7'd5}, "R4 bank0 untouched");
    rd_chk({2'd1, 7'd5}, "R4 bank1 untouched");
    rd_chk({2'd2, 7'd5}, "R4 bank2 untouched");
    rd_chk({2'd3, 7'd5}, "R4 bank3 reads zero");
    srch_req = 1'b1; a_addr = {2'd3, 7'd0};
    @(negedge clk);
    srch_req = 1'b0;
    @(negedge clk);
    check(res_valid === 1'b0, "R4 search on bank3", 32'(res_valid), 32'h0);

    // R6 sweep over starting banks and columns, back to back
    for (int k = 0; k < 60; k++) begin
      int r;
      int c;
      r = k % 10;
      c = (k * 7) % 30;
      srch_exp(pix(r, c), ref_srch(pix(r, c)), "R6 sweep");
    end
    repeat (3) @(negedge clk);

    // R7
    fill_win(4, 2, 10);
    wr_a(pix(5, 4), 32'hFFFF_0000);
    srch_exp(pix(4, 2), pix(5, 4), "R7 start column 2");
    fill_win(9, 3, 20);
    wr_a(pix(10, 5), 32'hFFFF_0001);
    srch_exp(pix(9, 3), pix(10, 5), "R7 start column 3");
    fill_win(0, 3, 30);
    wr_a(pix(2, 4), 32'hFFFF_0002);
    srch_exp(pix(0, 3), pix(2, 4), "R7 start column 3 last row");
    // R8
    fill_win(3, 5, 1);
    wr_a(pix(4, 6), 32'd900);
    wr_a(pix(4, 7), 32'd900);
    srch_exp(pix(3, 5), pix(4, 6), "R8 tie inside row");
    // R9
    fill_win(6, 10, 1);
    wr_a(pix(7, 12), 32'd777);
    wr_a(pix(8, 10), 32'd777);
    srch_exp(pix(6, 10), pix(7, 12), "R9 tie across rows");
    for (int i = 0; i < 3; i++)
      for (int j = 0; j < 3; j++)
        wr_a(pix(i, j), 32'd42);
    srch_exp(pix(0, 0), pix(0, 0), "R8 R9 all equal");
    // R12
    fill_win(1, 20, 1);
    wr_a(pix(1, 20), 32'h7FFF_FFFF);
    wr_a(pix(2, 21), 32'h8000_0000);
    srch_exp(pix(1, 20), pix(2, 21), "R12 unsigned compare");
    // R10
    fill_win(3, 20, 1);
    wr_a(pix(5, 21), 32'd5000);
    a_en = 1'b1; a_we = 1'b1; a_wdata = 32'hFFFF_FFFF;
    b_en = 1'b1; b_we = 1'b1; b_addr = pix(4, 22); b_wdata = 32'hFFFF_FFFE;
    srch_exp(pix(3, 20), pix(5, 21), "R10 writes during search");
    a_en = 1'b0; a_we = 1'b0; b_en = 1'b0; b_we = 1'b0;
    repeat (3) @(negedge clk);
    rd_chk(pix(3, 20), "R10 port A write blocked");
    rd_chk(pix(4, 22), "R10 port B write blocked");

    repeat (4) @(negedge clk);
    check(q_addr.size() == 0, "R5 results outstanding", 32'(q_addr.size()), 32'h0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule